// File: doc/BRIEF.md
# Four-Event Timestamp Capture Unit

The block timestamps edges of one input signal. The signal is picked from 128 candidates. Timestamps come from a free-running counter. Four capture slots are filled in turn by a 2-bit pointer. Each slot has its own edge sense, rising or falling, and its own choice of two timing modes:

- **Absolute timing:** the slot stores the raw counter value.
- **Delta timing:** the slot stores the value, and the counter then restarts from zero.

The unit can run continuously, using the slots as a four-deep ring. It can also run one-shot, where it stops after a programmed number of captures until software re-arms it.

Each capture raises a flag for its slot, and a counter wrap raises a fifth flag. An interrupt line stays high while any enabled flag is set. A one-cycle DMA request marks captures into one chosen slot. One of eight sync sources can load the counter with a programmed phase value. Software reaches everything through a simple synchronous register port. Writes take effect at the clock edge; reads are combinational from the address.

Register map (word address on `reg_addr`):

| Address | Name | Access and layout |
|---|---|---|
| 0 | CTRL | read/write, layout in R2 to R12 |
| 1 | STAT | read only: pointer in [1:0], armed in [2] |
| 2 | IEN | read/write: flag enables in [4:0] |
| 3 | FLAG | read gives the flags; writing 1 to a bit clears it |
| 4 | CNT | read/write: the counter |
| 5 | PHASE | read/write: the sync load value |
| 6 | CMD | write only: [0] re-arm, [1] filter reset; reads 0 |
| 8 to 11 | slots 0 to 3 | read only: captured values |

Top module: `evcap_top`

## Requirements
- R1: CTRL[21:15] selects which bit of `sig_in` is watched. Edges on any other bit never cause a capture.
- R2: CTRL[8:5] holds one edge-sense bit per slot, where 0 means rising and 1 means falling. The slot at the pointer captures only on its configured edge; the opposite edge is ignored.
- R3: In continuous mode (CTRL[1]=0) each capture writes the slot at the pointer and advances the pointer 0,1,2,3,0. A later capture overwrites an older one.
- R4: In one-shot mode (CTRL[1]=1) loading stops after the capture into slot CTRL[3:2]; STAT[2] then reads 0. Further edges leave the pointer and all slots unchanged. Writing 1 to CMD[0] sets the pointer to 0 and re-arms the unit.
- R5: With CTRL[0]=1 the counter increments every cycle. A capture stores the counter value, so the difference between two absolute captures equals the number of cycles between the two input edges. A capture lands three clock edges after the input changes.
- R6: When CTRL[9+k]=1 (delta timing for slot k), a capture into slot k stores the counter value from before the reset. The counter reads 0 in the next cycle and then counts up, so the next capture holds the edge spacing minus one.
- R7: A capture into slot k sets FLAG[k]. Writing 1 to FLAG bits clears them. `irq_o` is high exactly while some FLAG bit has its IEN bit set.
- R8: When the running counter wraps from all ones to zero, FLAG[4] is set.
- R9: STAT[1:0] always reads the index of the slot that will be loaded next. After reset STAT reads 4 (pointer 0, armed).
- R10: Writing 1 to CMD[1] clears the pointer, all flags and any edge still in flight in the detector. CMD reads as 0.
- R11: `dma_req_o` pulses high for exactly one cycle for each capture into the slot chosen by CTRL[14:13].
- R12: With CTRL[4]=1, a high cycle on `sync_src[CTRL[24:22]]` loads the counter with PHASE. With CTRL[4]=0 the sync input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 128 | Candidate capture inputs, asynchronous |
| sync_src | input | 8 | Candidate sync pulses, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_o | output | 1 | Interrupt level: any enabled flag set |
| dma_req_o | output | 1 | One-cycle request on the selected slot's capture |

## Verification
The checker assumes two things about the block's inputs:

- The watched input changes no more often than every second cycle, so a detected edge cannot coincide with the next one.
- The selected sync source is synchronous to the clock.

It also relies on the detector pipeline separating consecutive captures into the DMA slot by at least four edges. The stimulus spaces toggles of the watched line three or more cycles apart, whether random or directed. It drives sync as a single clean cycle at a falling clock edge. It changes the input selection only while the old and new lines sit at the same level, and then issues a filter reset.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

    localparam int NUM_EV     = 4;
    localparam int PTR_W      = $clog2(NUM_EV);
    localparam int IN_SEL_W   = 7;
    localparam int SYNC_SEL_W = 3;
    localparam int NUM_IN     = 1 << IN_SEL_W;
    localparam int NUM_SYNC   = 1 << SYNC_SEL_W;
    localparam int FLAG_W     = NUM_EV + 1;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 32;

    typedef enum logic [ADDR_W-1:0] {
        AD_CTRL  = 4'd0,
        AD_STAT  = 4'd1,
        AD_IEN   = 4'd2,
        AD_FLAG  = 4'd3,
        AD_CNT   = 4'd4,
        AD_PHASE = 4'd5,
        AD_CMD   = 4'd6
    } addr_e;

    // Control word, LSB last in this list: run is bit 0.
    typedef struct packed {
        logic [6:0]            rsv;
        logic [SYNC_SEL_W-1:0] sync_sel;
        logic [IN_SEL_W-1:0]   in_sel;
        logic [PTR_W-1:0]      dma_sel;
        logic [NUM_EV-1:0]     delta;
        logic [NUM_EV-1:0]     pol;
        logic                  sync_en;
        logic [PTR_W-1:0]      stop_at;
        logic                  oneshot;
        logic                  run;
    } ctrl_t;

endpackage

// File: rtl/evcap_edge.sv
module evcap_edge
    import evcap_pkg::*;
#(
    parameter int N_IN  = NUM_IN,
    parameter int SEL_W = IN_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  sig_in,
    input  logic [SEL_W-1:0] sel,
    input  logic             hist_clr,
    output logic             rise,
    output logic             fall
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d.s1 = sig_in[sel];
        pipe_d.s2 = pipe_q.s1;
        // a history clear makes the next compare see no change
        pipe_d.s3 = hist_clr ? pipe_q.s1 : pipe_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rise = pipe_q.s2 & ~pipe_q.s3;
    assign fall = ~pipe_q.s2 & pipe_q.s3;

endmodule

// File: rtl/evcap_rdmux.sv
module evcap_rdmux
    import evcap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            ctrl_word,
    input  logic [DATA_W-1:0]            stat_word,
    input  logic [FLAG_W-1:0]            ien,
    input  logic [FLAG_W-1:0]            flags,
    input  logic [CNT_W-1:0]             cnt,
    input  logic [CNT_W-1:0]             phase,
    input  logic [NUM_EV-1:0][CNT_W-1:0] cap,
    output logic [DATA_W-1:0]            rdata
);

    always_comb begin
        rdata = '0;
        case (addr)
            AD_CTRL:  rdata = ctrl_word;
            AD_STAT:  rdata = stat_word;
            AD_IEN:   rdata = DATA_W'(ien);
            AD_FLAG:  rdata = DATA_W'(flags);
            AD_CNT:   rdata = DATA_W'(cnt);
            AD_PHASE: rdata = DATA_W'(phase);
            default: begin
                if (addr[ADDR_W-1:PTR_W] == 2'b10)
                    rdata = DATA_W'(cap[addr[PTR_W-1:0]]);
            end
        endcase
    end

endmodule

// File: rtl/evcap_top.sv
module evcap_top
    import evcap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IN-1:0]   sig_in,
    input  logic [NUM_SYNC-1:0] sync_src,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq_o,
    output logic                dma_req_o
);

    typedef struct packed {
        ctrl_t                     ctrl;
        logic [FLAG_W-1:0]         ien;
        logic [CNT_W-1:0]          phase;
        logic [CNT_W-1:0]          cnt;
        logic [NUM_EV-1:0][CNT_W-1:0] cap;
        logic [PTR_W-1:0]          ptr;
        logic                      armed;
        logic [FLAG_W-1:0]         flags;
        logic                      dma;
    } state_t;

    state_t st_d, st_q;

    logic edge_rise, edge_fall;
    logic cmd_rearm, cmd_frst, cnt_wr, sync_hit;
    logic edge_ok, load_ok, cap_fire, delta_rst, ptr_forced;

    // strobes decoded from the bus and the configuration
    assign cmd_rearm  = reg_we && (reg_addr == AD_CMD) && reg_wdata[0];
    assign cmd_frst   = reg_we && (reg_addr == AD_CMD) && reg_wdata[1];
    assign cnt_wr     = reg_we && (reg_addr == AD_CNT);
    assign sync_hit   = st_q.ctrl.sync_en && sync_src[st_q.ctrl.sync_sel];
    assign edge_ok    = st_q.ctrl.pol[st_q.ptr] ? edge_fall : edge_rise;
    assign load_ok    = !st_q.ctrl.oneshot || st_q.armed;
    assign ptr_forced = cmd_rearm || cmd_frst;
    assign cap_fire   = edge_ok && load_ok && !ptr_forced;
    assign delta_rst  = cap_fire && st_q.ctrl.delta[st_q.ptr];

    evcap_edge #(
        .N_IN (NUM_IN),
        .SEL_W(IN_SEL_W)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_in  (sig_in),
        .sel     (st_q.ctrl.in_sel),
        .hist_clr(cmd_frst),
        .rise    (edge_rise),
        .fall    (edge_fall)
    );

    always_comb begin
        st_d     = st_q;
        st_d.dma = 1'b0;

        // flag clear first so that a same-cycle set wins
        if (reg_we && reg_addr == AD_FLAG)
            st_d.flags = st_q.flags & ~reg_wdata[FLAG_W-1:0];

        // counter: bus write > sync load > delta restart > count
        if (cnt_wr) begin
            st_d.cnt = reg_wdata[CNT_W-1:0];
        end else if (sync_hit) begin
            st_d.cnt = st_q.phase;
        end else if (delta_rst) begin
            st_d.cnt = '0;
        end else if (st_q.ctrl.run) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (&st_q.cnt) st_d.flags[NUM_EV] = 1'b1;
        end

        if (cap_fire) begin
            st_d.cap[st_q.ptr]   = st_q.cnt;
            st_d.flags[st_q.ptr] = 1'b1;
            st_d.ptr             = st_q.ptr + PTR_W'(1);
            if (st_q.ptr == st_q.ctrl.dma_sel) st_d.dma = 1'b1;
            if (st_q.ctrl.oneshot && st_q.ptr == st_q.ctrl.stop_at)
                st_d.armed = 1'b0;
        end

        if (cmd_rearm) begin
            st_d.armed = 1'b1;
            st_d.ptr   = '0;
        end

        if (cmd_frst) begin
            st_d.ptr   = '0;
            st_d.flags = '0;
        end

        if (reg_we) begin
            case (reg_addr)
                AD_CTRL:  st_d.ctrl  = ctrl_t'(reg_wdata);
                AD_IEN:   st_d.ien   = reg_wdata[FLAG_W-1:0];
                AD_PHASE: st_d.phase = reg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // named views for the bound checker
    logic                         run_w, oneshot_w, armed_w;
    logic [CNT_W-1:0]             cnt_w;
    logic [PTR_W-1:0]             ptr_w;
    logic [FLAG_W-1:0]            flags_w;
    logic [NUM_EV-1:0][CNT_W-1:0] cap_w;

    assign run_w     = st_q.ctrl.run;
    assign oneshot_w = st_q.ctrl.oneshot;
    assign armed_w   = st_q.armed;
    assign cnt_w     = st_q.cnt;
    assign ptr_w     = st_q.ptr;
    assign flags_w   = st_q.flags;
    assign cap_w     = st_q.cap;

    evcap_rdmux #(
        .CNT_W(CNT_W)
    ) u_rdmux (
        .addr     (reg_addr),
        .ctrl_word(DATA_W'(st_q.ctrl)),
        .stat_word({{(DATA_W-PTR_W-1){1'b0}}, st_q.armed, st_q.ptr}),
        .ien      (st_q.ien),
        .flags    (st_q.flags),
        .cnt      (st_q.cnt),
        .phase    (st_q.phase),
        .cap      (st_q.cap),
        .rdata    (reg_rdata)
    );

    assign irq_o     = |(st_q.flags & st_q.ien);
    assign dma_req_o = st_q.dma;

endmodule

// File: rtl/evcap_chk.sv
module evcap_chk
    import evcap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         run,
    input logic                         oneshot,
    input logic                         armed,
    input logic [CNT_W-1:0]             cnt_q,
    input logic [PTR_W-1:0]             ptr_q,
    input logic [FLAG_W-1:0]            flags_q,
    input logic [NUM_EV-1:0][CNT_W-1:0] cap,
    input logic                         cap_fire,
    input logic                         delta_rst,
    input logic                         cnt_wr,
    input logic                         sync_hit,
    input logic                         ptr_forced,
    input logic                         frst,
    input logic                         dma_req_o
);

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire && !ptr_forced |=> ptr_q == $past(ptr_q) + PTR_W'(1));

    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_fire && !ptr_forced |=> $stable(ptr_q));

    p_oneshot_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        oneshot && !armed |=> $stable(cap));

    p_count_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run && !cnt_wr && !sync_hit && !delta_rst |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    p_delta_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        delta_rst && !cnt_wr && !sync_hit |=> cnt_q == '0);

    p_flag_on_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> $countones(flags_q[NUM_EV-1:0]) >= 1);

    p_wrap_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run && (&cnt_q) && !cnt_wr && !sync_hit && !delta_rst && !frst |=> flags_q[NUM_EV]);

    p_dma_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o |=> !dma_req_o);

endmodule

bind evcap_top evcap_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_w),
    .oneshot   (oneshot_w),
    .armed     (armed_w),
    .cnt_q     (cnt_w),
    .ptr_q     (ptr_w),
    .flags_q   (flags_w),
    .cap       (cap_w),
    .cap_fire  (cap_fire),
    .delta_rst (delta_rst),
    .cnt_wr    (cnt_wr),
    .sync_hit  (sync_hit),
    .ptr_forced(ptr_forced),
    .frst      (cmd_frst),
    .dma_req_o (dma_req_o)
);

// File: tb/test_evcap_top.sv
module test_evcap_top;
    import evcap_pkg::*;

    localparam int CLK_P = 10;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [NUM_IN-1:0]   sig_in;
    logic [NUM_SYNC-1:0] sync_src;
    logic                reg_we;
    logic [ADDR_W-1:0]   reg_addr;
    logic [DATA_W-1:0]   reg_wdata;
    logic [DATA_W-1:0]   reg_rdata;
    logic                irq_o, dma_req_o;

    always #(CLK_P/2) clk = ~clk;

    evcap_top i_evcap_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_in   (sig_in),
        .sync_src (sync_src),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_o    (irq_o),
        .dma_req_o(dma_req_o)
    );

    int n_chk = 0, n_bad = 0, dma_cnt = 0;
    int sel = 5;
    logic lvl = 1'b0;
    int gp[4];
    logic [31:0] c[4], r, c0_old, c2_old, v0, v1;

    always @(negedge clk) if (dma_req_o) dma_cnt++;

    function automatic logic [31:0] mk_ctrl(logic run, logic os, logic [1:0] stop,
                                            logic sen, logic [3:0] pol, logic [3:0] dlt,
                                            logic [1:0] dsel, logic [6:0] isel, logic [2:0] ssel);
        ctrl_t cw;
        cw = '0;
        cw.run = run; cw.oneshot = os; cw.stop_at = stop; cw.sync_en = sen;
        cw.pol = pol; cw.delta = dlt; cw.dma_sel = dsel; cw.in_sel = isel; cw.sync_sel = ssel;
        return 32'(cw);
    endfunction

    // expected: does a change to newlvl match the slot's edge sense
    function automatic logic hits(logic [3:0] pol, int p, logic newlvl);
        return pol[p] ? !newlvl : newlvl;
    endfunction

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic tog();
        @(negedge clk);
        lvl = !lvl;
        sig_in[sel] = lvl;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic run4();
        for (int k = 0; k < 4; k++) begin
            gp[k] = 4 + int'($urandom % 20);
            tog();
            repeat (gp[k] - 1) @(negedge clk);
        end
        settle();
    endtask

    task automatic read_caps();
        for (int k = 0; k < 4; k++) rd(4'(8 + k), c[k]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        void'($urandom(32'd1457));
        rst_n = 1'b0; sig_in = '0; sync_src = '0;
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(AD_STAT, r); chk("R9 reset status", r, 32'h4);
        rd(AD_FLAG, r); chk("R7 reset flags", r, 32'h0);
        chk("R7 reset irq", 32'(irq_o), 32'h0);
        chk("R11 reset dma", 32'(dma_req_o), 32'h0);

        // continuous, absolute, alternating edge senses
        wr(AD_CTRL, mk_ctrl(1, 0, 0, 0, 4'b1010, 4'b0000, 2'd2, 7'd5, 3'd0));
        wr(AD_IEN, 32'h0F);
        run4();
        read_caps();
        for (int k = 0; k < 3; k++) chk("R5 absolute spacing", c[k+1] - c[k], 32'(gp[k]));
        rd(AD_STAT, r); chk("R3 pointer wraps to 0", r, 32'h4);
        rd(AD_FLAG, r); chk("R7 flags per slot", r, 32'hF);
        chk("R7 irq high", 32'(irq_o), 32'h1);
        c0_old = c[0];
        run4();
        read_caps();
        for (int k = 0; k < 3; k++) chk("R5 absolute spacing round 2", c[k+1] - c[k], 32'(gp[k]));
        chk("R3 slot 0 overwritten", 32'(c[0] != c0_old), 32'h1);
        chk("R11 one pulse per pass", 32'(dma_cnt), 32'h2);
        tog(); settle();
        rd(AD_STAT, r); chk("R9 pointer after one", r, 32'h5);

        // interrupt enables and clearing
        wr(AD_IEN, 32'h0);  chk("R7 irq masked", 32'(irq_o), 32'h0);
        wr(AD_IEN, 32'h1F); chk("R7 irq unmasked", 32'(irq_o), 32'h1);
        wr(AD_FLAG, 32'h1); rd(AD_FLAG, r); chk("R7 clear one", r, 32'hE);
        wr(AD_FLAG, 32'h1E); rd(AD_FLAG, r); chk("R7 clear rest", r, 32'h0);
        chk("R7 irq low", 32'(irq_o), 32'h0);

        // filter reset
        tog(); settle();
        wr(AD_CMD, 32'h2);
        rd(AD_STAT, r); chk("R10 pointer cleared", r, 32'h4);
        rd(AD_FLAG, r); chk("R10 flags cleared", r, 32'h0);
        rd(AD_CMD, r); chk("R10 command reads zero", r, 32'h0);

        // edge sense: slot 0 wants rising
        tog(); settle();
        wr(AD_CMD, 32'h2);
        tog(); settle();
        rd(AD_STAT, r); chk("R2 falling ignored by rising slot", r, 32'h4);
        rd(AD_FLAG, r); chk("R2 no flag on wrong edge", r, 32'h0);
        tog(); settle();
        rd(AD_STAT, r); chk("R2 rising captured", r, 32'h5);
        tog(); settle();
        rd(AD_STAT, r); chk("R2 falling captured by falling slot", r, 32'h6);

        // input select
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); sig_in[6] = ~sig_in[6];
            repeat (4) @(negedge clk);
        end
        settle();
        rd(AD_STAT, r); chk("R1 other line ignored", r, 32'h6);
        wr(AD_CTRL, mk_ctrl(1, 0, 0, 0, 4'b1010, 4'b0000, 2'd2, 7'd77, 3'd0));
        wr(AD_CMD, 32'h2);
        sel = 77; lvl = sig_in[77];
        tog(); settle();
        rd(AD_STAT, r); chk("R1 new line captured", r, 32'h5);

        // delta timing on all slots
        wr(AD_CTRL, mk_ctrl(1, 0, 0, 0, 4'b1010, 4'b1111, 2'd2, 7'd77, 3'd0));
        tog();
        repeat (3) @(negedge clk);
        rd(AD_CNT, r); chk("R6 counter zero after capture", r, 32'h0);
        @(negedge clk);
        rd(AD_CNT, r); chk("R6 counter resumes", r, 32'h1);
        settle();
        run4();
        read_caps();
        for (int k = 0; k < 3; k++) chk("R6 delta value", c[(3 + k) % 4], 32'(gp[k] - 1));

        // one-shot stopping after slot 1
        wr(AD_CTRL, mk_ctrl(1, 1, 2'd1, 0, 4'b1010, 4'b0000, 2'd2, 7'd77, 3'd0));
        wr(AD_CMD, 32'h1);
        wr(AD_FLAG, 32'h1F);
        rd(4'd10, c2_old);
        for (int k = 0; k < 4; k++) begin tog(); repeat (5) @(negedge clk); end
        settle();
        rd(AD_STAT, r); chk("R4 stopped and disarmed", r, 32'h2);
        rd(4'd10, r); chk("R4 slot 2 untouched", r, c2_old);
        rd(AD_FLAG, r); chk("R4 only two flags", r, 32'h3);
        wr(AD_CMD, 32'h1);
        rd(AD_STAT, r); chk("R4 rearm", r, 32'h4);
        tog(); settle();
        rd(AD_STAT, r); chk("R4 loads after rearm", r, 32'h5);

        // sync load
        wr(AD_CTRL, mk_ctrl(1, 0, 0, 1, 4'b1010, 4'b0000, 2'd2, 7'd77, 3'd3));
        wr(AD_PHASE, 32'h1234_0000);
        sync_src[3] = 1'b1;
        @(negedge clk);
        rd(AD_CNT, r); chk("R12 phase loaded", r, 32'h1234_0000);
        sync_src[3] = 1'b0;
        @(negedge clk);
        rd(AD_CNT, r); chk("R12 counts from phase", r, 32'h1234_0001);
        wr(AD_CTRL, mk_ctrl(1, 0, 0, 0, 4'b1010, 4'b0000, 2'd2, 7'd77, 3'd3));
        rd(AD_CNT, v0);
        sync_src[3] = 1'b1;
        @(negedge clk);
        rd(AD_CNT, v1);
        sync_src[3] = 1'b0;
        chk("R12 sync ignored when disabled", v1, v0 + 32'd1);

        // counter wrap
        wr(AD_FLAG, 32'h1F);
        wr(AD_CNT, 32'hFFFF_FFFD);
        repeat (4) @(negedge clk);
        rd(AD_CNT, r); chk("R8 counter wrapped", r, 32'h1);
        rd(AD_FLAG, r); chk("R8 wrap flag", r, 32'h10);
        chk("R8 irq on wrap", 32'(irq_o), 32'h1);

        // random edge senses and spacing against a bench model
        for (int pass = 0; pass < 4; pass++) begin
            logic [3:0] pol;
            int mptr;
            logic [4:0] mflags;
            pol = 4'($urandom);
            wr(AD_CTRL, mk_ctrl(1, 0, 0, 0, pol, 4'b0000, 2'd0, 7'd77, 3'd0));
            wr(AD_CMD, 32'h2);
            mptr = 0; mflags = '0;
            for (int t = 0; t < 24; t++) begin
                if (hits(pol, mptr, !lvl)) begin
                    mflags[mptr] = 1'b1;
                    mptr = (mptr + 1) % 4;
                end
                tog();
                repeat (2 + int'($urandom % 6)) @(negedge clk);
            end
            settle();
            rd(AD_STAT, r); chk("R2 random pointer", r, 32'(4 + mptr));
            rd(AD_FLAG, r); chk("R7 random flags", r, 32'(mflags));
        end

        report();
    end

endmodule